// File: doc/BRIEF.md
# Code Prefetch Queue

This block is the instruction-fetch half of a processor bus interface. It keeps up to six code bytes ready for the execution side. It fetches code ahead of use through a simple request/acknowledge memory port. The byte address of each fetch is the 16-bit code segment value shifted left four places plus the 16-bit fetch pointer, truncated to 20 bits. A fetch at an even address returns two bytes. A fetch at an odd address returns one byte, so the next fetch is aligned again.

The execution side takes bytes from the head of the queue. With each byte it says whether the byte opens a new instruction or continues the current one. A jump request loads a new segment and pointer, empties the queue and abandons any fetch in flight. Every cycle a 2-bit queue status reports what happened at the previous clock edge, so that a coprocessor watching the bus can follow the instruction stream.

The raw reset input is filtered. The block resets only after the input has been high for a number of consecutive clocks.

Top module: `code_prefetch_queue`

## Requirements
- R1: A reset takes effect only after `rst_in` has been sampled high on 4 consecutive clock edges. A shorter pulse leaves the queue contents and the pending fetch untouched.
- R2: After reset the queue is empty, `q_status` is 00, and the first fetch goes to segment FFFFh, pointer 0000h, which is byte address FFFF0h.
- R3: Every fetch address equals (segment × 16 + pointer) mod 2^20. For example, 2915h:0003h gives 29153h, and FFFFh:0010h wraps to 00000h.
- R4: A new fetch starts only when at least two of the six byte slots are free, so the queue never holds more than six bytes.
- R5: An even-address fetch appends two bytes: `mem_rdata[7:0]` first, then `mem_rdata[15:8]`, and the pointer advances by 2. An odd-address fetch appends only `mem_rdata[15:8]`, and the pointer advances by 1.
- R6: `byte_valid` is high exactly when the queue is non-empty, and `byte_data` shows the oldest byte. A take while the queue is empty has no effect.
- R7: `q_status` is registered and describes the previous edge: 01 when a byte was taken with `take_first` high, 11 when a byte was taken with `take_first` low, and 00 when nothing happened.
- R8: A jump empties the queue, drops any fetch in flight (including one acknowledged in the same cycle), ignores a take in the same cycle, loads the new segment and pointer, and gives `q_status` 10.
- R9: A take and a fetch completion in the same cycle both take effect, and the byte order and occupancy stay correct.
- R10: Once `mem_req` is raised, it and `mem_addr` stay unchanged until `mem_ack` or a jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Raw active-high reset, filtered internally |
| jump_valid | input | 1 | Load a new segment and pointer and empty the queue |
| jump_cs | input | 16 | New code segment value |
| jump_ip | input | 16 | New fetch pointer value |
| take_req | input | 1 | Execution side takes the head byte this cycle |
| take_first | input | 1 | The taken byte starts a new instruction |
| byte_valid | output | 1 | Queue is non-empty |
| byte_data | output | 8 | Oldest byte in the queue |
| q_status | output | 2 | Queue activity of the previous edge |
| mem_req | output | 1 | Code fetch request |
| mem_addr | output | 20 | Byte address of the fetch |
| mem_ack | input | 1 | Fetch completes this cycle; data valid |
| mem_rdata | input | 16 | Aligned word containing the fetched byte(s) |

## Verification
Some rules are checked by assertions on every cycle:
- the request-hold rule;
- the room threshold at each fetch start;
- the occupancy bound;
- no take from an empty queue;
- the status code after a jump and after a take or an idle cycle.

Other behaviour only the directed scenarios can show:
- the actual byte order after odd and even fetches;
- address wrap;
- an exact occupancy after a simultaneous take and completion;
- a jump colliding with an acknowledge;
- the difference between a three-clock and a four-clock reset pulse.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    localparam int SEG_W    = 16;
    localparam int SEG_SHIFT = 4;

endpackage

// File: rtl/pfq_reset_filter.sv
module pfq_reset_filter #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_in,
    output logic core_rst
);
    localparam int RW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_in) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != RW'(HOLD)) begin
            st_d.cnt = st_q.cnt + RW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign core_rst = (st_q.cnt == RW'(HOLD));

endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
    parameter int DEPTH = 6,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          pop,
    input  logic [1:0]    push_cnt,
    input  logic [15:0]   push_word,
    output logic [7:0]    head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [CW-1:0] base;

    always_comb begin
        st_d = st_q;
        base = st_q.cnt - CW'(pop);
        for (int i = 0; i < DEPTH; i++) begin
            if (pop && (i < DEPTH - 1)) begin
                st_d.mem[i] = st_q.mem[i + 1];
            end
            if ((push_cnt != 2'd0) && (CW'(i) == base)) begin
                st_d.mem[i] = push_word[7:0];
            end
            if ((push_cnt == 2'd2) && (CW'(i) == base + CW'(1))) begin
                st_d.mem[i] = push_word[15:8];
            end
        end
        st_d.cnt = base + CW'(push_cnt);
        if (flush) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[0];
    assign count = st_q.cnt;

    // R4: storage never receives more bytes than it has slots
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        !flush |-> (int'(st_q.cnt) - int'(pop) + int'(push_cnt)) <= DEPTH);

    // R6: the controller never pops an empty queue
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> st_q.cnt != '0);

endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int          QDEPTH   = 6,
    parameter int          ADDR_W   = 20,
    parameter int          RST_HOLD = 4,
    parameter logic [15:0] CS_RESET = 16'hFFFF,
    parameter logic [15:0] IP_RESET = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_in,
    input  logic              jump_valid,
    input  logic [15:0]       jump_cs,
    input  logic [15:0]       jump_ip,
    input  logic              take_req,
    input  logic              take_first,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic [1:0]        q_status,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata
);
    localparam int CW = $clog2(QDEPTH + 1);

    typedef struct packed {
        logic [SEG_W-1:0]  cs;
        logic [SEG_W-1:0]  ip;
        logic              busy;
        logic              odd;
        logic [ADDR_W-1:0] addr;
        qstat_e            stat;
    } ctl_t;

    ctl_t st_d, st_q;

    logic          core_rst;
    logic          pop;
    logic [1:0]    push_cnt;
    logic [15:0]   push_word;
    logic [CW-1:0] fifo_cnt;
    logic [7:0]    fifo_head;

    pfq_reset_filter #(.HOLD(RST_HOLD)) u_rst (
        .clk      (clk),
        .rst_in   (rst_in),
        .core_rst (core_rst)
    );

    pfq_byte_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk       (clk),
        .rst       (core_rst),
        .flush     (jump_valid),
        .pop       (pop),
        .push_cnt  (push_cnt),
        .push_word (push_word),
        .head      (fifo_head),
        .count     (fifo_cnt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.stat = QS_IDLE;
        pop       = 1'b0;
        push_cnt  = 2'd0;
        push_word = st_q.odd ? {8'h00, mem_rdata[15:8]} : mem_rdata;
        if (jump_valid) begin
            st_d.cs   = jump_cs;
            st_d.ip   = jump_ip;
            st_d.busy = 1'b0;
            st_d.stat = QS_FLUSH;
        end else begin
            if (take_req && (fifo_cnt != '0)) begin
                pop       = 1'b1;
                st_d.stat = take_first ? QS_FIRST : QS_NEXT;
            end
            if (st_q.busy) begin
                if (mem_ack) begin
                    st_d.busy = 1'b0;
                    push_cnt  = st_q.odd ? 2'd1 : 2'd2;
                end
            end else if (fifo_cnt <= CW'(QDEPTH - 2)) begin
                st_d.busy = 1'b1;
                st_d.odd  = st_q.ip[0];
                st_d.addr = ADDR_W'({st_q.cs, {SEG_SHIFT{1'b0}}}) + ADDR_W'(st_q.ip);
                st_d.ip   = st_q.ip + (st_q.ip[0] ? 16'd1 : 16'd2);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (core_rst) begin
            st_q.cs   <= CS_RESET;
            st_q.ip   <= IP_RESET;
            st_q.busy <= 1'b0;
            st_q.odd  <= 1'b0;
            st_q.addr <= '0;
            st_q.stat <= QS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_valid = (fifo_cnt != '0);
    assign byte_data  = fifo_head;
    assign q_status   = st_q.stat;
    assign mem_req    = st_q.busy;
    assign mem_addr   = st_q.addr;

    // R10: a raised request holds its address until acknowledged or jumped
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (core_rst)
        (mem_req && !mem_ack && !jump_valid) |=> (mem_req && $stable(mem_addr)));

    // R4: a fetch only begins when two slots are free
    assert_room_R4: assert property (@(posedge clk) disable iff (core_rst)
        (!mem_req && !jump_valid && (fifo_cnt > CW'(QDEPTH - 2))) |=> !mem_req);

    // R8: a jump leaves an empty queue, no request and the flush code
    assert_flush_R8: assert property (@(posedge clk) disable iff (core_rst)
        jump_valid |=> (q_status == 2'b10 && !byte_valid && !mem_req));

    // R7: a first-byte take reports 01, an idle cycle reports 00
    assert_first_R7: assert property (@(posedge clk) disable iff (core_rst)
        (take_req && take_first && byte_valid && !jump_valid) |=> q_status == 2'b01);
    assert_idle_R7: assert property (@(posedge clk) disable iff (core_rst)
        (!take_req && !jump_valid) |=> q_status == 2'b00);

endmodule

// File: tb/code_prefetch_queue_bench.sv
module code_prefetch_queue_bench;

    logic        clk = 1'b0;
    logic        rst_in = 1'b1;
    logic        jump_valid = 1'b0;
    logic [15:0] jump_cs = '0;
    logic [15:0] jump_ip = '0;
    logic        take_req = 1'b0;
    logic        take_first = 1'b0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic [1:0]  q_status;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    logic [19:0] last_addr;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    code_prefetch_queue u_code_prefetch_queue (
        .clk        (clk),
        .rst_in     (rst_in),
        .jump_valid (jump_valid),
        .jump_cs    (jump_cs),
        .jump_ip    (jump_ip),
        .take_req   (take_req),
        .take_first (take_first),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .q_status   (q_status),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5};
    endfunction

    function automatic logic [15:0] mword(input logic [19:0] a);
        return {mb({a[19:1], 1'b1}), mb({a[19:1], 1'b0})};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic serve(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            while (!mem_req) @(negedge clk);
            last_addr = mem_addr;
            mem_rdata = mword(mem_addr);
            mem_ack   = 1'b1;
            @(negedge clk);
            mem_ack   = 1'b0;
        end
    endtask

    task automatic take_byte(input logic [19:0] a, input bit first, input string req);
        @(negedge clk);
        check(byte_valid == 1'b1, req, byte_valid, 1);
        check(byte_data == mb(a), req, byte_data, mb(a));
        take_req = 1'b1;
        take_first = first;
        @(negedge clk);
        take_req = 1'b0;
        check(q_status == (first ? 2'b01 : 2'b11), "R7", q_status, first ? 2'b01 : 2'b11);
    endtask

    task automatic do_jump(input logic [15:0] cs, input logic [15:0] ip);
        @(negedge clk);
        jump_cs = cs;
        jump_ip = ip;
        jump_valid = 1'b1;
        @(negedge clk);
        jump_valid = 1'b0;
        check(q_status == 2'b10, "R8 status", q_status, 2'b10);
        check(!byte_valid && !mem_req, "R8 empty", {byte_valid, mem_req}, 0);
    endtask

    task automatic pulse_reset(input int n);
        @(negedge clk);
        rst_in = 1'b1;
        repeat (n) @(negedge clk);
        rst_in = 1'b0;
    endtask

    task automatic t_reset;
        rst_in = 1'b0;
        @(negedge clk);
        pulse_reset(4);
        @(negedge clk);
        check(!byte_valid, "R2 empty", byte_valid, 0);
        check(q_status == 2'b00, "R2 status", q_status, 0);
        @(negedge clk);
        check(mem_req && mem_addr == 20'hFFFF0, "R2 first fetch", mem_addr, 20'hFFFF0);
        repeat (3) @(negedge clk);
        check(mem_req && mem_addr == 20'hFFFF0, "R10 hold", mem_addr, 20'hFFFF0);
    endtask

    task automatic t_fill;
        serve(3);
        repeat (2) @(negedge clk);
        check(!mem_req, "R4 full no fetch", mem_req, 0);
        take_byte(20'hFFFF0, 1'b1, "R6 head");
        check(!mem_req, "R4 five held", mem_req, 0);
        take_byte(20'hFFFF1, 1'b0, "R6 order");
        check(!mem_req, "R4 start next edge", mem_req, 0);
        @(negedge clk);
        check(mem_req && mem_addr == 20'hFFFF6, "R4 room fetch", mem_addr, 20'hFFFF6);
        for (int i = 2; i < 6; i++) take_byte(20'hFFFF0 + 20'(i), 1'b0, "R4 six bytes");
        check(!byte_valid, "R4 drained", byte_valid, 0);
        @(negedge clk);
        take_req = 1'b1;
        @(negedge clk);
        take_req = 1'b0;
        check(q_status == 2'b00, "R6 empty take status", q_status, 0);
        serve(1);
        take_byte(20'hFFFF6, 1'b1, "R6 empty take ignored");
    endtask

    task automatic t_odd;
        do_jump(16'h2915, 16'h0003);
        serve(1);
        check(last_addr == 20'h29153, "R3 odd address", last_addr, 20'h29153);
        take_byte(20'h29153, 1'b1, "R5 odd byte");
        check(!byte_valid, "R5 single byte", byte_valid, 0);
        serve(1);
        check(last_addr == 20'h29154, "R5 realign", last_addr, 20'h29154);
        take_byte(20'h29154, 1'b0, "R5 low first");
        take_byte(20'h29155, 1'b0, "R5 high second");
    endtask

    task automatic t_wrap;
        do_jump(16'hFFFF, 16'h0010);
        serve(1);
        check(last_addr == 20'h00000, "R3 wrap", last_addr, 0);
        take_byte(20'h00000, 1'b1, "R3 wrap data");
    endtask

    task automatic t_simul;
        do_jump(16'h0100, 16'h0000);
        serve(1);
        @(negedge clk);
        while (!mem_req) @(negedge clk);
        check(mem_addr == 20'h01002, "R9 pending", mem_addr, 20'h01002);
        check(byte_data == mb(20'h01000), "R9 head", byte_data, mb(20'h01000));
        mem_rdata = mword(mem_addr);
        mem_ack = 1'b1;
        take_req = 1'b1;
        take_first = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        take_req = 1'b0;
        check(q_status == 2'b01, "R9 take status", q_status, 2'b01);
        for (int i = 1; i < 4; i++) take_byte(20'h01000 + 20'(i), 1'b0, "R9 order");
        check(!byte_valid, "R9 occupancy", byte_valid, 0);
    endtask

    task automatic t_flush_collide;
        serve(1);
        @(negedge clk);
        while (!mem_req) @(negedge clk);
        check(byte_valid, "R8 preload", byte_valid, 1);
        jump_cs = 16'h0200;
        jump_ip = 16'h0001;
        jump_valid = 1'b1;
        take_req = 1'b1;
        mem_rdata = mword(mem_addr);
        mem_ack = 1'b1;
        @(negedge clk);
        jump_valid = 1'b0;
        take_req = 1'b0;
        mem_ack = 1'b0;
        check(q_status == 2'b10, "R8 collide status", q_status, 2'b10);
        check(!byte_valid, "R8 ack dropped", byte_valid, 0);
        serve(1);
        check(last_addr == 20'h02001, "R8 new address", last_addr, 20'h02001);
        take_byte(20'h02001, 1'b1, "R8 new stream");
    endtask

    task automatic t_short_reset;
        serve(1);
        @(negedge clk);
        while (!mem_req) @(negedge clk);
        check(byte_valid && byte_data == mb(20'h02002), "R1 preload", byte_data, mb(20'h02002));
        pulse_reset(3);
        repeat (2) @(negedge clk);
        check(byte_valid && byte_data == mb(20'h02002), "R1 short pulse ignored", byte_data, mb(20'h02002));
        check(mem_req && mem_addr == 20'h02004, "R1 fetch kept", mem_addr, 20'h02004);
        pulse_reset(4);
        @(negedge clk);
        check(!byte_valid, "R1 long pulse resets", byte_valid, 0);
        serve(1);
        check(last_addr == 20'hFFFF0, "R1 restart address", last_addr, 20'hFFFF0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        t_fill();
        t_odd();
        t_wrap();
        t_simul();
        t_flush_collide();
        t_short_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule